// File: doc/BRIEF.md
# Round-Robin Packet Dispatcher

The dispatcher sits between several packet input channels and a bank of processing-element input FIFOs. It reads one whole packet at a time from one channel and copies every word of that packet, in order, into a single destination FIFO. Input channels are served in a fair rotation. Destinations are chosen by which FIFOs currently report room, with the search starting just after the destination used last, so that work spreads over all processing elements.

Each channel word carries a data field plus one boundary flag that marks the final word of a packet. Once a packet has been granted a channel and a destination, both are held until its final word has moved. If the chosen FIFO fills up mid-packet, the dispatcher stops accepting words from the channel rather than losing them. It resumes when room returns. Selecting a packet takes one cycle. After that one word can move per cycle.

Top module: `rr_pkt_dispatcher`

## Requirements
- R1: A channel word is DATA_W+1 bits wide. Bits [DATA_W-1:0] are data and bit DATA_W is the end-of-packet flag, set only on a packet's last word. Every accepted word appears on `pe_word` with all bits unchanged.
- R2: All words of a packet go to the same destination. No word of another channel moves until the current packet's last word has moved. At most one `src_ready` bit and one `pe_push` bit are high at a time.
- R3: After a packet from channel c completes, the next channel search starts at c+1, wrapping after NUM_CH-1.
- R4: During the search, channels without valid data are skipped in the same cycle. A waiting channel is granted in the first selection cycle, however many empty channels lie ahead of it in the rotation.
- R5: At packet start, the destination is the lowest-index FIFO with `pe_room` set, searching upward from the index after the previously used destination and wrapping. After reset the search starts at index 0.
- R6: While the chosen FIFO's `pe_room` is low, `src_ready` and `pe_push` stay low and the pending word is held. No word is ever dropped, and a push happens only into a FIFO with room.
- R7: No packet is started while every `pe_room` bit is low.
- R8: After reset all `src_ready` and `pe_push` bits are low.
- R9: A packet is selected on the first clock edge where a channel is valid and a destination has room. Its granted channel sees `src_ready` high from the next cycle onward. After the last word there is one selection cycle before the next packet's first word.
- R10: The channel rotation pointer does not change while a packet is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | NUM_CH | Per-channel word-valid |
| src_word | input | NUM_CH*(DATA_W+1) | Channel words, channel c at slice c |
| src_ready | output | NUM_CH | Per-channel accept; a word moves when valid and ready are both high at a clock edge |
| pe_room | input | NUM_PE | Destination FIFO can accept a word this cycle |
| pe_push | output | NUM_PE | One-hot write strobe toward the destination FIFOs |
| pe_word | output | DATA_W+1 | Word written to the strobed FIFO |

## Verification
On every cycle the assertions check the following: at most one push and one accept, pushes only into a FIFO with room, every push matched by an accepted word, grant and destination held through a packet, and the rotation pointer frozen mid-packet. Only the bench scenarios can show the rest. These are the exact destination picked under each room pattern, the service order when several channels compete with empty channels in between, the one-cycle selection latency, and that a stalled word later reaches the same FIFO intact.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  typedef enum logic {
    ST_SELECT = 1'b0,
    ST_MOVE   = 1'b1
  } disp_state_t;
endpackage

// File: rtl/rr_pick.sv
// Rotating-priority picker: first set request at or after 'start', wrapping.
module rr_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    int p;
    hit = 1'b0;
    idx = start;
    // walk from farthest to nearest so the nearest request wins
    for (int k = N - 1; k >= 0; k--) begin
      p = int'(start) + k;
      if (p >= N) p = p - N;
      if (req[p]) begin
        hit = 1'b1;
        idx = p[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/word_sel.sv
// Selects one channel's word out of the flattened channel bus.
module word_sel #(
  parameter int NUM_CH = 4,
  parameter int WORD_W = 33,
  parameter int CW     = $clog2(NUM_CH)
) (
  input  logic [NUM_CH*WORD_W-1:0] flat,
  input  logic [CW-1:0]            sel,
  output logic [WORD_W-1:0]        word
);
  assign word = flat[sel*WORD_W +: WORD_W];
endmodule

// File: rtl/rr_pkt_dispatcher.sv
module rr_pkt_dispatcher
  import dispatch_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NUM_PE = 8,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CH-1:0]            src_valid,
  input  logic [NUM_CH*(DATA_W+1)-1:0] src_word,
  output logic [NUM_CH-1:0]            src_ready,
  input  logic [NUM_PE-1:0]            pe_room,
  output logic [NUM_PE-1:0]            pe_push,
  output logic [DATA_W:0]              pe_word
);
  localparam int WORD_W = DATA_W + 1;
  localparam int CW     = $clog2(NUM_CH);
  localparam int PW     = $clog2(NUM_PE);
  localparam logic [CW-1:0] CH_LAST = CW'(NUM_CH - 1);
  localparam logic [PW-1:0] PE_LAST = PW'(NUM_PE - 1);

  disp_state_t   state;
  logic [CW-1:0] grant;
  logic [PW-1:0] dest;
  logic [CW-1:0] rr_ptr;
  logic [PW-1:0] dst_last;
  logic [PW-1:0] dst_start;

  logic          ch_hit, pe_hit;
  logic [CW-1:0] ch_idx;
  logic [PW-1:0] pe_idx;
  logic [WORD_W-1:0] cur_word;
  logic          moving, room_ok, fire, done;

  assign dst_start = (dst_last == PE_LAST) ? '0 : dst_last + 1'b1;

  rr_pick #(.N(NUM_CH), .IW(CW)) u_ch_pick (
    .req(src_valid), .start(rr_ptr), .hit(ch_hit), .idx(ch_idx)
  );

  rr_pick #(.N(NUM_PE), .IW(PW)) u_pe_pick (
    .req(pe_room), .start(dst_start), .hit(pe_hit), .idx(pe_idx)
  );

  word_sel #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .CW(CW)) u_word_sel (
    .flat(src_word), .sel(grant), .word(cur_word)
  );

  assign moving  = (state == ST_MOVE);
  assign room_ok = moving && pe_room[dest];
  assign fire    = room_ok && src_valid[grant];
  assign done    = fire && cur_word[DATA_W];
  assign pe_word = cur_word;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ready
    assign src_ready[c] = room_ok && (grant == CW'(c));
  end

  for (genvar d = 0; d < NUM_PE; d++) begin : g_push
    assign pe_push[d] = fire && (dest == PW'(d));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_SELECT;
      grant    <= '0;
      dest     <= '0;
      rr_ptr   <= '0;
      dst_last <= PE_LAST;
    end else begin
      case (state)
        ST_SELECT: begin
          if (ch_hit && pe_hit) begin
            grant <= ch_idx;
            dest  <= pe_idx;
            state <= ST_MOVE;
          end
        end
        default: begin
          if (done) begin
            state    <= ST_SELECT;
            rr_ptr   <= (grant == CH_LAST) ? '0 : grant + 1'b1;
            dst_last <= dest;
          end
        end
      endcase
    end
  end

  AST_PUSH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pe_push)); // R2
  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_ready)); // R2
  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
    (|pe_push) |-> (|(pe_push & pe_room))); // R6
  AST_PUSH_IS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (|pe_push) |-> (|(src_ready & src_valid))); // R6
  AST_HOLD_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (moving && !done) |=> (moving && $stable(grant) && $stable(dest))); // R2
  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (moving && !done) |=> $stable(rr_ptr)); // R10
  AST_NO_START_FULL: assert property (@(posedge clk) disable iff (rst)
    (!moving && pe_room == '0) |=> !moving); // R7
endmodule

// File: tb/rr_pkt_dispatcher_tb.sv
module rr_pkt_dispatcher_tb_top;
  localparam int NUM_CH = 4;
  localparam int NUM_PE = 8;
  localparam int DATA_W = 32;
  localparam int WW     = DATA_W + 1;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic [NUM_CH-1:0]      src_valid = '0;
  logic [NUM_CH*WW-1:0]   src_word  = '0;
  logic [NUM_CH-1:0]      src_ready;
  logic [NUM_PE-1:0]      pe_room = '0;
  logic [NUM_PE-1:0]      pe_push;
  logic [WW-1:0]          pe_word;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk; // 125 MHz

  rr_pkt_dispatcher #(.NUM_CH(NUM_CH), .NUM_PE(NUM_PE), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_word(src_word),
    .src_ready(src_ready), .pe_room(pe_room), .pe_push(pe_push), .pe_word(pe_word)
  );

  // {channel, length, room mask, expected destination}
  localparam logic [31:0] VEC [8] = '{
    {8'd0, 8'd3, 8'hFF, 8'd0},
    {8'd2, 8'd1, 8'hFF, 8'd1},
    {8'd1, 8'd2, 8'h81, 8'd7},
    {8'd3, 8'd4, 8'h06, 8'd1},
    {8'd0, 8'd2, 8'h01, 8'd0},
    {8'd1, 8'd1, 8'hFF, 8'd1},
    {8'd2, 8'd5, 8'h40, 8'd6},
    {8'd3, 8'd2, 8'h30, 8'd4}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] mk_word(input int tag, input int i, input int len);
    return {(i == len - 1) ? 1'b1 : 1'b0, 16'hA5C3, 8'(tag), 8'(i)};
  endfunction

  // Sends one packet on channel ch; optionally removes room before word stall_at.
  task automatic send_pkt(input int ch, input int len, input logic [7:0] room,
                          input int exp_dest, input int tag, input int stall_at);
    int i = 0;
    int guard = 0;
    pe_room = room;
    while (i < len && guard < 200) begin
      @(negedge clk);
      guard++;
      src_valid[ch] = 1'b1;
      src_word[ch*WW +: WW] = mk_word(tag, i, len);
      if (i == stall_at) begin
        pe_room = '0;
        for (int s = 0; s < 3; s++) begin
          #1;
          check(src_ready == '0 && pe_push == '0, "R6 stall",
                {src_ready, pe_push}, 0);
          @(negedge clk);
        end
        pe_room = room;
        stall_at = -1;
      end
      #1;
      if (src_ready[ch]) begin
        check(pe_push == NUM_PE'(1 << exp_dest), "R5 R2 destination", pe_push,
              NUM_PE'(1 << exp_dest));
        check(pe_word == mk_word(tag, i, len), "R1 word content", pe_word,
              mk_word(tag, i, len));
        i++;
      end
    end
    check(guard < 200, "R9 packet completes", guard, len);
    @(negedge clk);
    src_valid[ch] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(src_ready == '0, "R8 reset ready", src_ready, 0);
    check(pe_push == '0, "R8 reset push", pe_push, 0);

    // table walk: R1 R2 R5 R9
    foreach (VEC[n]) begin
      send_pkt(int'(VEC[n][31:24]), int'(VEC[n][23:16]), VEC[n][15:8],
               int'(VEC[n][7:0]), n, -1);
    end

    // stall mid-packet on channel 1 into PE2: R6
    send_pkt(1, 4, 8'h04, 2, 20, 2);

    // no room anywhere: R7
    pe_room = '0;
    @(negedge clk);
    src_valid[0] = 1'b1;
    src_word[0 +: WW] = mk_word(30, 0, 1);
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      #1;
      check(src_ready == '0 && pe_push == '0, "R7 no start when full",
            {src_ready, pe_push}, 0);
    end
    send_pkt(0, 1, 8'hFF, 3, 30, -1);

    // competing channels 0 and 2, pointer at 1: R3 R4 R9 R2
    begin
      int cnt [NUM_CH];
      logic [NUM_CH-1:0] exp_rdy [8];
      int exp_dst [NUM_CH];
      exp_rdy = '{4'b0000, 4'b0100, 4'b0100, 4'b0000,
                  4'b0001, 4'b0001, 4'b0000, 4'b0000};
      exp_dst = '{5, 0, 4, 0};
      foreach (cnt[c]) cnt[c] = 0;
      pe_room = 8'hFF;
      @(negedge clk);
      for (int t = 0; t < 8; t++) begin
        if (t > 0) @(negedge clk);
        for (int c = 0; c < NUM_CH; c += 2) begin
          src_valid[c] = (cnt[c] < 2);
          src_word[c*WW +: WW] = mk_word(40 + c, cnt[c], 2);
        end
        #1;
        check(src_ready == exp_rdy[t], "R3 R4 R9 service order", src_ready,
              exp_rdy[t]);
        for (int c = 0; c < NUM_CH; c++) begin
          if (src_ready[c] && src_valid[c]) begin
            check(pe_push == NUM_PE'(1 << exp_dst[c]), "R2 R5 competing dest",
                  pe_push, NUM_PE'(1 << exp_dst[c]));
            cnt[c]++;
          end
        end
      end
      src_valid = '0;
    end

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule